// File: doc/BRIEF.md
# Digital Silence Kill Detector

This block watches the left and right PCM words of an audio stream before interpolation filtering and drives active-low kill outputs once digital silence has lasted long enough. A word counts as silent when every bit is zero or every bit is one. Each channel has its own run counter. On every accepted sample, the counter moves up by one when that channel's word is silent and goes back to zero when it is not. A channel is qualified once its counter reaches `HOLD_SAMPLES`. The default of 8820 samples equals 200 ms at 44.1 kHz.

A mode input selects one of two output arrangements. In joint mode, a single kill line goes low only while both channels are qualified, and the auxiliary line stays high. In split mode, the kill line follows the left channel and the auxiliary line follows the right channel. A mute input forces the kill line low in both modes. Both outputs are registered.

Top module: `silence_kill_top`

## Requirements
- R1: A word is silent exactly when all of its `DATA_W` bits are 0 or all are 1; every other value is non-silent.
- R2: A channel becomes qualified on the clock edge that accepts its `HOLD_SAMPLES`-th consecutive silent sample (strobe `sample_valid` high), and not one sample earlier.
- R3: A non-silent sample clears that channel's run, and its output returns high on the edge that accepts that sample.
- R4: The run counter saturates at `HOLD_SAMPLES`, so an arbitrarily long silent run keeps the channel qualified.
- R5: With `mode_sel` = 0 (joint), `kill_n` is low only while both channels are qualified, and `aux_n` is held at 1.
- R6: With `mode_sel` = 1 (split), `kill_n` is low exactly while the left channel is qualified, and `aux_n` is low exactly while the right channel is qualified.
- R7: While `mute` is 1, `kill_n` is driven 0 in either mode; `mute` has no effect on `aux_n`.
- R8: Words presented while `sample_valid` is 0 are ignored and leave the run state unchanged.
- R9: After reset both outputs are 1 and both runs are empty.
- R10: Outputs are registered: a change in `mode_sel` or `mute`, or an accepted sample, shows at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Sample strobe; the words are accepted on this cycle |
| left_word | input | DATA_W | Left PCM word |
| right_word | input | DATA_W | Right PCM word |
| mode_sel | input | 1 | 0 = joint output, 1 = split per-channel outputs |
| mute | input | 1 | Forces `kill_n` low |
| kill_n | output | 1 | Active-low kill (joint, or left in split mode) |
| aux_n | output | 1 | Active-low right-channel kill in split mode; 1 in joint mode |

## Verification
The bench uses a 4-bit word and a hold of five samples. It sweeps all sixteen word values through both channels. A classifier that accepted only zeros, or that missed all ones, would leave a qualified output high or pull a loud one low. The bench checks the sample just before the threshold and the sample that reaches it, which exposes an off-by-one in qualification. It also runs silence well past the counter's natural wrap point, so a counter that does not saturate would briefly release the output. Further cases cover a loud sample in the middle of a run, one channel qualifying while the other is loud in joint mode, mode switching and mute toggling without strobes, and loud words held without a strobe. These expose a joint mode that ORs instead of ANDs, a mute that reaches the auxiliary line, and a strobe gate that is missing.

// File: rtl/silence_kill_pkg.sv
package silence_kill_pkg;

    typedef enum logic {
        KILL_JOINT = 1'b0,
        KILL_SPLIT = 1'b1
    } kill_mode_e;

    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned CHAN_L   = 0;
    localparam int unsigned CHAN_R   = 1;

    typedef struct packed {
        logic kill_n;
        logic aux_n;
    } kill_out_t;

endpackage

// File: rtl/silence_word_chk.sv
module silence_word_chk #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    output logic              silent_o
);
    logic all_zero;
    logic all_one;

    always_comb begin
        all_zero = ~|word_i;
        all_one  = &word_i;
        silent_o = all_zero | all_one;
    end
endmodule

// File: rtl/silence_run_timer.sv
module silence_run_timer #(
    parameter int unsigned HOLD_SAMPLES = 8820,
    parameter int unsigned CNT_W        = $clog2(HOLD_SAMPLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic             silent_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             qual_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_SAMPLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            if (!silent_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        qual_next_o = (st_d.cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/silence_kill_top.sv
module silence_kill_top
    import silence_kill_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned HOLD_SAMPLES = 8820,
    localparam int unsigned CNT_W       = $clog2(HOLD_SAMPLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] left_word,
    input  logic [DATA_W-1:0] right_word,
    input  logic              mode_sel,
    input  logic              mute,
    output logic              kill_n,
    output logic              aux_n
);
    logic [NUM_CHAN-1:0][DATA_W-1:0] chan_word;
    logic [NUM_CHAN-1:0]             chan_silent;
    logic [NUM_CHAN-1:0][CNT_W-1:0]  chan_cnt;
    logic [NUM_CHAN-1:0]             chan_qual_next;

    assign chan_word[CHAN_L] = left_word;
    assign chan_word[CHAN_R] = right_word;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        silence_word_chk #(
            .DATA_W (DATA_W)
        ) u_word_chk (
            .word_i   (chan_word[ch]),
            .silent_o (chan_silent[ch])
        );

        silence_run_timer #(
            .HOLD_SAMPLES (HOLD_SAMPLES),
            .CNT_W        (CNT_W)
        ) u_run_timer (
            .clk         (clk),
            .rst_n       (rst_n),
            .strobe_i    (sample_valid),
            .silent_i    (chan_silent[ch]),
            .cnt_o       (chan_cnt[ch]),
            .qual_next_o (chan_qual_next[ch])
        );
    end

    kill_out_t  out_d, out_q;
    kill_mode_e mode;

    always_comb begin
        mode  = kill_mode_e'(mode_sel);
        out_d = out_q;
        unique case (mode)
            KILL_JOINT: begin
                out_d.kill_n = ~((chan_qual_next[CHAN_L] & chan_qual_next[CHAN_R]) | mute);
                out_d.aux_n  = 1'b1;
            end
            KILL_SPLIT: begin
                out_d.kill_n = ~(chan_qual_next[CHAN_L] | mute);
                out_d.aux_n  = ~chan_qual_next[CHAN_R];
            end
            default: begin
                out_d.kill_n = 1'b1;
                out_d.aux_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{kill_n: 1'b1, aux_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign kill_n = out_q.kill_n;
    assign aux_n  = out_q.aux_n;
endmodule

// File: rtl/silence_kill_chk.sv
module silence_kill_chk #(
    parameter int unsigned HOLD_SAMPLES = 8820,
    parameter int unsigned CNT_W        = $clog2(HOLD_SAMPLES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             mode_sel,
    input logic             mute,
    input logic             kill_n,
    input logic             aux_n,
    input logic [1:0]       chan_silent,
    input logic [1:0][CNT_W-1:0] chan_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_SAMPLES);

    assert_count_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_cnt[0] <= CNT_MAX) && (chan_cnt[1] <= CNT_MAX));

    assert_loud_clears_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !chan_silent[0]) |=> (chan_cnt[0] == '0));

    assert_silent_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && chan_silent[1] && chan_cnt[1] != CNT_MAX)
            |=> (chan_cnt[1] == $past(chan_cnt[1]) + CNT_W'(1)));

    assert_no_strobe_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(chan_cnt[0]) && $stable(chan_cnt[1])));

    assert_mute_forces_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> !kill_n);

    assert_joint_aux_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> aux_n);

    assert_split_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !mute) |=> (kill_n != (chan_cnt[0] == CNT_MAX)));

    assert_split_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |=> (aux_n != (chan_cnt[1] == CNT_MAX)));
endmodule

bind silence_kill_top silence_kill_chk #(
    .HOLD_SAMPLES (HOLD_SAMPLES),
    .CNT_W        (CNT_W)
) u_silence_kill_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .mode_sel     (mode_sel),
    .mute         (mute),
    .kill_n       (kill_n),
    .aux_n        (aux_n),
    .chan_silent  (chan_silent),
    .chan_cnt     (chan_cnt)
);

// File: tb/silence_kill_top_bench.sv
`timescale 1ns/1ps
module silence_kill_top_bench;
    localparam int unsigned DW   = 4;
    localparam int unsigned HOLD = 5;
    localparam logic [DW-1:0] ZERO = '0;
    localparam logic [DW-1:0] ONES = '1;
    localparam logic [DW-1:0] LOUD = DW'(5);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_valid = 1'b0;
    logic [DW-1:0] left_word = '0;
    logic [DW-1:0] right_word = '0;
    logic          mode_sel = 1'b0;
    logic          mute = 1'b0;
    logic          kill_n;
    logic          aux_n;

    int checks = 0;
    int fails = 0;
    int mc_l = 0;
    int mc_r = 0;

    always #2 clk = ~clk;

    silence_kill_top #(
        .DATA_W       (DW),
        .HOLD_SAMPLES (HOLD)
    ) u_silence_kill_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .left_word    (left_word),
        .right_word   (right_word),
        .mode_sel     (mode_sel),
        .mute         (mute),
        .kill_n       (kill_n),
        .aux_n        (aux_n)
    );

    function automatic bit is_quiet(input logic [DW-1:0] w);
        return (w == ZERO) || (w == ONES);
    endfunction

    function automatic int next_run(input int c, input logic [DW-1:0] w);
        if (!is_quiet(w)) return 0;
        return (c >= int'(HOLD)) ? int'(HOLD) : c + 1;
    endfunction

    task automatic check(input string req);
        logic ek, ea;
        bit ql, qr;
        ql = (mc_l == int'(HOLD));
        qr = (mc_r == int'(HOLD));
        if (mode_sel) begin
            ek = !(ql || mute);
            ea = !qr;
        end else begin
            ek = !((ql && qr) || mute);
            ea = 1'b1;
        end
        checks++;
        if (kill_n !== ek || aux_n !== ea) begin
            fails++;
            $display("FAIL %s: kill_n=%b aux_n=%b expected kill_n=%b aux_n=%b (runs L=%0d R=%0d)",
                     req, kill_n, aux_n, ek, ea, mc_l, mc_r);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input logic v, input string req);
        left_word    = l;
        right_word   = r;
        sample_valid = v;
        @(negedge clk);
        sample_valid = 1'b0;
        if (v) begin
            mc_l = next_run(mc_l, l);
            mc_r = next_run(mc_r, r);
        end
        check(req);
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        checks++;
        $display("FAIL R9: watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release");

        // R1 / R2 / R3: sweep every word value through both channels, split mode.
        mode_sel = 1'b1;
        @(negedge clk);
        check("R10 mode change");
        for (int v = 0; v < (1 << DW); v++) begin
            for (int k = 0; k < int'(HOLD); k++) begin
                step(DW'(v), DW'((1 << DW) - 1 - v), 1'b1, "R1 sweep / R2 threshold");
            end
            step(LOUD, LOUD, 1'b1, "R3 loud clears run");
        end

        // R2: sample before the threshold stays high, the threshold sample qualifies.
        for (int k = 0; k < int'(HOLD) - 1; k++) step(ZERO, ONES, 1'b1, "R2 below threshold");
        step(ZERO, ONES, 1'b1, "R2 at threshold");

        // R4: long run past the counter wrap point.
        for (int k = 0; k < 40; k++) step(ONES, ZERO, 1'b1, "R4 saturation");

        // R8: loud words without strobe are ignored.
        for (int k = 0; k < 6; k++) step(LOUD, LOUD, 1'b0, "R8 no strobe");

        // R3: a loud sample mid-run on left only.
        step(LOUD, ZERO, 1'b1, "R3 left release");
        step(ZERO, ZERO, 1'b1, "R3 left restarts");

        // R5: joint mode, one channel qualified, the other loud.
        mode_sel = 1'b0;
        @(negedge clk);
        check("R5 mode to joint");
        for (int k = 0; k < int'(HOLD) + 2; k++) step(ZERO, LOUD, 1'b1, "R5 right loud");
        for (int k = 0; k < int'(HOLD) + 1; k++) step(ZERO, ONES, 1'b1, "R5 both quiet");
        step(LOUD, ONES, 1'b1, "R5 left breaks joint");

        // R7: mute in both modes, without strobes.
        mute = 1'b1;
        @(negedge clk);
        check("R7 mute joint");
        mode_sel = 1'b1;
        @(negedge clk);
        check("R7 mute split, aux unaffected");
        for (int k = 0; k < int'(HOLD); k++) step(LOUD, ZERO, 1'b1, "R7 mute with right quiet");
        mute = 1'b0;
        @(negedge clk);
        check("R7 mute released");

        // R6: split mode, left quiet and right loud, then swapped.
        for (int k = 0; k < int'(HOLD); k++) step(ONES, LOUD, 1'b1, "R6 left only");
        mode_sel = 1'b0;
        @(negedge clk);
        check("R6 left only seen in joint");
        mode_sel = 1'b1;
        @(negedge clk);
        check("R10 back to split");

        // R9: reset mid-run clears state.
        rst_n = 1'b0;
        mc_l = 0;
        mc_r = 0;
        @(negedge clk);
        check("R9 reset mid-run");
        rst_n = 1'b1;
        step(ZERO, ZERO, 1'b1, "R9 first sample after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule